// File: doc/BRIEF.md
# Binary Floating-Point Adder/Subtractor

This block adds or subtracts two floating-point words. Each word holds a sign, a biased exponent and a fraction. The default format is the 32-bit single-precision layout, and the field widths are parameters. A per-operation select chooses between sum and difference.

The datapath runs in two registered stages:

- **Stage 1** decodes both operands and spots special values. It orders the operands by magnitude, shifts the smaller significand right to line it up with the larger one, and either adds or subtracts the two magnitudes.
- **Stage 2** normalizes the raw result with a leading-zero count, or with a one-place right shift when the sum carries out. It then rounds to nearest with ties to even, renormalizes if rounding carries out, and repacks the word.

Overflow, underflow (flush to zero) and invalid results are each reported on their own flag. A valid strobe travels with each operation, so a new operation can be issued on every cycle. A controller steps the operation through both stages, and the datapath holds the arithmetic.

Top module: `fpAddSub`

## Requirements
- R1: Words are laid out as sign in the top bit, then an EXP_W-bit exponent biased by 2^(EXP_W-1)-1, then an FRAC_W-bit fraction in the low bits. Nonzero exponents carry a hidden leading 1. With the defaults, 0x43802000 + 0x43B2E000 gives 0x44198000, and 0x47B30CB8 + 0x43B2E000 gives 0x47B3BF98.
- R2: With subOp=0 the result is opA+opB, and with subOp=1 it is opA-opB. Magnitudes are added when the effective signs agree and subtracted otherwise. A subtraction takes the sign of the larger-magnitude operand, with opB's sign inverted when subOp=1.
- R3: Results are rounded to nearest, with ties to even, using guard, round and sticky bits kept through alignment. A carry out of rounding renormalizes the result and raises the exponent by one.
- R4: When an effective subtraction cancels exactly, the result is +0. Adding two zeros of the same effective sign gives a zero of that sign.
- R5: A rounded exponent at or above the all-ones code returns an infinity of the result's sign, with flagOvf=1.
- R6: An exponent field of 0 denotes zero or a denormal, with hidden bit 0 and the same effective exponent as code 1. A nonzero rounded result whose exponent falls below code 1 is flushed to a zero of its sign, with flagUdf=1.
- R7: Any NaN operand (exponent all ones, fraction nonzero) returns the quiet NaN: sign 0, exponent all ones, fraction MSB 1 and all other fraction bits 0. Infinities of opposite effective sign return the same quiet NaN with flagInv=1. At most one flag is set at a time.
- R8: When only one operand is infinite, or both are infinite with the same effective sign, the result is that infinity with its effective sign, and no flag is set.
- R9: A result appears with outValid=1 exactly two clock cycles after inValid=1 is sampled, and operations may be issued back to back. In a cycle with no result, outValid=0 and result and the flags hold their previous values.
- R10: While rstN=0, outValid, result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and select are valid this cycle |
| opA | input | 1+EXP_W+FRAC_W | First operand |
| opB | input | 1+EXP_W+FRAC_W | Second operand |
| subOp | input | 1 | 0 adds, 1 subtracts opB from opA |
| outValid | output | 1 | result and flags carry a new value |
| result | output | 1+EXP_W+FRAC_W | Rounded, packed result |
| flagOvf | output | 1 | Result overflowed to infinity |
| flagUdf | output | 1 | Nonzero result flushed to zero |
| flagInv | output | 1 | Infinity minus infinity |

## Verification
Some paths are rarely reached from random 32-bit operands:

- a rounding carry that forces a second renormalization;
- an exact tie that has to go to even;
- a cancellation that leaves a result just under the normal range.

To reach them, the bench also builds the block with a 4-bit exponent and a 3-bit fraction and drives every operand pair with both operation selects. It compares each result against an exact real-valued model rounded in the bench, so every tie, rounding carry, denormal, infinity and NaN combination of that format occurs. Directed 32-bit cases then cover the worked sums, the tie-to-even pair and each flag.

// File: rtl/fpAddPkg.sv
package fpAddPkg;
  // strobes from the controller into the datapath
  typedef struct packed {
    logic ld1;  // capture aligned sum into stage 1
    logic ld2;  // capture packed result into output stage
  } fpStrobe_t;
endpackage

// File: rtl/fpAddLzc.sv
module fpAddLzc #(
  parameter int WIDTH = 28,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [CW-1:0]    count
);
  always_comb begin
    count = CW'(WIDTH);
    for (int i = 0; i < WIDTH; i++) begin
      if (vec[i]) count = CW'(WIDTH - 1 - i);
    end
  end
endmodule

// File: rtl/fpAddControl.sv
module fpAddControl
  import fpAddPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output fpStrobe_t strb,
  output logic      outValid
);
  logic stage1Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
    end
  end

  assign strb.ld1 = inValid;
  assign strb.ld2 = stage1Valid;
endmodule

// File: rtl/fpAddDatapath.sv
module fpAddDatapath
  import fpAddPkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  fpStrobe_t    strb,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         subOp,
  output logic [W-1:0] result,
  output logic         flagOvf,
  output logic         flagUdf,
  output logic         flagInv
);
  localparam int P   = FRAC_W + 1;      // significand with hidden bit
  localparam int XW  = P + 3;           // plus guard, round, sticky
  localparam int SW  = XW + 1;          // plus carry
  localparam int EW2 = EXP_W + 2;       // signed working exponent
  localparam int ZW  = $clog2(SW + 1);
  localparam logic [EXP_W-1:0] EMAX = '1;
  localparam logic signed [EW2-1:0] ONE = EW2'(1);
  localparam logic [W-1:0] QNAN = {1'b0, EMAX, 1'b1, {(FRAC_W-1){1'b0}}};

  // ---------------- stage 1: unpack, order, align, add ----------------
  logic              aSign, bSign, aNan, bNan, aInf, bInf, aMagGe, effSub;
  logic [EXP_W-1:0]  aExp, bExp, bigExp, smallExp, bigEff, smallEff, diff;
  logic [FRAC_W-1:0] aFrac, bFrac, bigFrac, smallFrac;
  logic [XW-1:0]     bigMan, smallMan, alignedSmall;
  logic [2*XW-1:0]   wide;
  logic [SW-1:0]     sumRaw;
  int                shAmt;
  logic              nanNext, infNext, invNext, infSignNext, signNext;

  always_comb begin
    aSign = opA[W-1];
    aExp  = opA[W-2:FRAC_W];
    aFrac = opA[FRAC_W-1:0];
    bSign = opB[W-1] ^ subOp;
    bExp  = opB[W-2:FRAC_W];
    bFrac = opB[FRAC_W-1:0];
    aNan  = (aExp == EMAX) && (aFrac != '0);
    bNan  = (bExp == EMAX) && (bFrac != '0);
    aInf  = (aExp == EMAX) && (aFrac == '0);
    bInf  = (bExp == EMAX) && (bFrac == '0);
    aMagGe    = opA[W-2:0] >= opB[W-2:0];
    bigExp    = aMagGe ? aExp : bExp;
    smallExp  = aMagGe ? bExp : aExp;
    bigFrac   = aMagGe ? aFrac : bFrac;
    smallFrac = aMagGe ? bFrac : aFrac;
    bigEff    = (bigExp == '0) ? EXP_W'(1) : bigExp;
    smallEff  = (smallExp == '0) ? EXP_W'(1) : smallExp;
    diff      = bigEff - smallEff;
    bigMan    = {bigExp != '0, bigFrac, 3'b000};
    smallMan  = {smallExp != '0, smallFrac, 3'b000};
    shAmt     = (int'(diff) > XW) ? XW : int'(diff);
    wide      = {smallMan, {XW{1'b0}}} >> shAmt;
    alignedSmall = wide[2*XW-1:XW] | {{(XW-1){1'b0}}, |wide[XW-1:0]};
    effSub    = aSign ^ bSign;
    sumRaw    = effSub ? ({1'b0, bigMan} - {1'b0, alignedSmall})
                       : ({1'b0, bigMan} + {1'b0, alignedSmall});
    signNext    = aMagGe ? aSign : bSign;
    invNext     = aInf && bInf && effSub;
    nanNext     = aNan || bNan || invNext;
    infNext     = (aInf || bInf) && !nanNext;
    infSignNext = aInf ? aSign : bSign;
  end

  logic [SW-1:0]    s1Sum;
  logic [EXP_W-1:0] s1Exp;
  logic             s1Sign, s1EffSub, s1Nan, s1Inv, s1Inf, s1InfSign;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Sum <= '0; s1Exp <= '0; s1Sign <= 1'b0; s1EffSub <= 1'b0;
      s1Nan <= 1'b0; s1Inv <= 1'b0; s1Inf <= 1'b0; s1InfSign <= 1'b0;
    end else if (strb.ld1) begin
      s1Sum <= sumRaw; s1Exp <= bigEff; s1Sign <= signNext; s1EffSub <= effSub;
      s1Nan <= nanNext; s1Inv <= invNext; s1Inf <= infNext; s1InfSign <= infSignNext;
    end
  end

  // ---------------- stage 2: normalize, round, pack ----------------
  logic [ZW-1:0]            zCnt, shl;
  logic signed [EW2-1:0]    expWide, normExp, finalExp;
  logic [XW-1:0]            normMan;
  logic [P-1:0]             sig;
  logic [P:0]               rnd;
  logic [FRAC_W-1:0]        finalFrac;
  logic                     roundUp;
  logic [W-1:0]             nextRes;
  logic                     nextOvf, nextUdf, nextInv;

  fpAddLzc #(.WIDTH(SW)) lzc (.vec(s1Sum), .count(zCnt));

  always_comb begin
    expWide = $signed({2'b00, s1Exp});
    shl     = zCnt - ZW'(1);
    if (s1Sum[SW-1]) begin
      normMan = {s1Sum[SW-1:2], s1Sum[1] | s1Sum[0]};
      normExp = expWide + ONE;
    end else begin
      normMan = s1Sum[XW-1:0] << shl;
      normExp = expWide - $signed({{(EW2-ZW){1'b0}}, shl});
    end
    sig     = normMan[XW-1:3];
    roundUp = normMan[2] & (normMan[1] | normMan[0] | sig[0]);
    rnd     = {1'b0, sig} + (P+1)'(roundUp);
    if (rnd[P]) begin
      finalFrac = rnd[FRAC_W:1];
      finalExp  = normExp + ONE;
    end else begin
      finalFrac = rnd[FRAC_W-1:0];
      finalExp  = normExp;
    end
    nextOvf = 1'b0; nextUdf = 1'b0; nextInv = 1'b0;
    if (s1Nan) begin
      nextRes = QNAN;
      nextInv = s1Inv;
    end else if (s1Inf) begin
      nextRes = {s1InfSign, EMAX, {FRAC_W{1'b0}}};
    end else if (s1Sum == '0) begin
      nextRes = {s1EffSub ? 1'b0 : s1Sign, {(W-1){1'b0}}};
    end else if (finalExp >= $signed({2'b00, EMAX})) begin
      nextRes = {s1Sign, EMAX, {FRAC_W{1'b0}}};
      nextOvf = 1'b1;
    end else if (finalExp < ONE) begin
      nextRes = {s1Sign, {(W-1){1'b0}}};
      nextUdf = 1'b1;
    end else begin
      nextRes = {s1Sign, finalExp[EXP_W-1:0], finalFrac};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0; flagOvf <= 1'b0; flagUdf <= 1'b0; flagInv <= 1'b0;
    end else if (strb.ld2) begin
      result <= nextRes; flagOvf <= nextOvf; flagUdf <= nextUdf; flagInv <= nextInv;
    end
  end

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ld2 |=> $stable(result) && $stable({flagOvf, flagUdf, flagInv}));
  a_r7_single_flag: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flagOvf, flagUdf, flagInv}));
  a_r5_ovf_is_inf: assert property (@(posedge clk) disable iff (!rstN)
    flagOvf |-> (result[W-2:FRAC_W] == EMAX) && (result[FRAC_W-1:0] == '0));
  a_r7_inv_is_nan: assert property (@(posedge clk) disable iff (!rstN)
    flagInv |-> (result == QNAN));
  a_r6_udf_is_zero: assert property (@(posedge clk) disable iff (!rstN)
    flagUdf |-> (result[W-2:0] == '0));
endmodule

// File: rtl/fpAddSub.sv
module fpAddSub
  import fpAddPkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [EXP_W+FRAC_W:0]   opA,
  input  logic [EXP_W+FRAC_W:0]   opB,
  input  logic                    subOp,
  output logic                    outValid,
  output logic [EXP_W+FRAC_W:0]   result,
  output logic                    flagOvf,
  output logic                    flagUdf,
  output logic                    flagInv
);
  fpStrobe_t strb;

  fpAddControl ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strb(strb), .outValid(outValid)
  );

  fpAddDatapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opA(opA), .opB(opB), .subOp(subOp),
    .result(result), .flagOvf(flagOvf), .flagUdf(flagUdf), .flagInv(flagInv)
  );
endmodule

// File: tb/fpAddSub_test.sv
module fpAddSub_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic bValid = 1'b0, bSub = 1'b0;
  logic [31:0] bA = '0, bB = '0;
  logic bOutV, bOvf, bUdf, bInv;
  logic [31:0] bRes;

  logic mValid = 1'b0, mSub = 1'b0;
  logic [7:0] mA = '0, mB = '0;
  logic mOutV, mOvf, mUdf, mInv;
  logic [7:0] mRes;

  fpAddSub uut (
    .clk(clk), .rstN(rstN), .inValid(bValid), .opA(bA), .opB(bB), .subOp(bSub),
    .outValid(bOutV), .result(bRes), .flagOvf(bOvf), .flagUdf(bUdf), .flagInv(bInv)
  );

  fpAddSub #(.EXP_W(4), .FRAC_W(3)) uutMini (
    .clk(clk), .rstN(rstN), .inValid(mValid), .opA(mA), .opB(mB), .subOp(mSub),
    .outValid(mOutV), .result(mRes), .flagOvf(mOvf), .flagUdf(mUdf), .flagInv(mInv)
  );

  int checks = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic report(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic real p2(input int k);
    real r = 1.0;
    if (k >= 0) repeat (k) r = r * 2.0;
    else repeat (-k) r = r / 2.0;
    return r;
  endfunction

  // exact model: returns {ovf, udf, inv, word}
  function automatic logic [66:0] refAdd(input int ew, input int fw, input logic [63:0] a,
                                         input logic [63:0] b, input logic sub);
    int bias, emax, ea, eb, e, be;
    longint fmask, fa, fb, ip;
    logic sa, sb, s;
    real va, vb, v, m, scaled;
    logic [63:0] qnan, word;
    bias = (1 << (ew - 1)) - 1;
    emax = (1 << ew) - 1;
    fmask = (longint'(1) << fw) - 1;
    ea = int'((a >> fw) & 64'(emax));
    eb = int'((b >> fw) & 64'(emax));
    fa = longint'(a) & fmask;
    fb = longint'(b) & fmask;
    sa = a[ew+fw];
    sb = b[ew+fw] ^ sub;
    qnan = (64'(emax) << fw) | (64'd1 << (fw - 1));
    if ((ea == emax && fa != 0) || (eb == emax && fb != 0)) return {3'b000, qnan};
    if (ea == emax && eb == emax && sa != sb) return {3'b001, qnan};
    if (ea == emax) return {3'b000, (64'(sa) << (ew + fw)) | (64'(emax) << fw)};
    if (eb == emax) return {3'b000, (64'(sb) << (ew + fw)) | (64'(emax) << fw)};
    va = (ea == 0) ? real'(fa) * p2(1 - bias - fw)
                   : real'(fa + (longint'(1) << fw)) * p2(ea - bias - fw);
    vb = (eb == 0) ? real'(fb) * p2(1 - bias - fw)
                   : real'(fb + (longint'(1) << fw)) * p2(eb - bias - fw);
    v = (sa ? -va : va) + (sb ? -vb : vb);
    if (v == 0.0) begin
      s = (sa == sb) ? sa : 1'b0;
      return {3'b000, 64'(s) << (ew + fw)};
    end
    s = (v < 0.0);
    m = s ? -v : v;
    e = 0;
    while (m >= p2(e + 1)) e++;
    while (m < p2(e)) e--;
    scaled = m / p2(e - fw);
    ip = longint'($floor(scaled));
    if ((scaled - real'(ip) > 0.5) || ((scaled - real'(ip) == 0.5) && ip[0])) ip++;
    if (ip == (longint'(1) << (fw + 1))) begin
      ip = ip >> 1;
      e++;
    end
    be = e + bias;
    if (be >= emax) return {3'b100, (64'(s) << (ew + fw)) | (64'(emax) << fw)};
    if (be < 1) return {3'b010, 64'(s) << (ew + fw)};
    word = (64'(s) << (ew + fw)) | (64'(be) << fw) | 64'(ip - (longint'(1) << fw));
    return {3'b000, word};
  endfunction

  // ---- 32-bit pipeline bookkeeping ----
  logic bQv[2] = '{1'b0, 1'b0};
  logic [31:0] bQr[2];
  logic [2:0] bQf[2];
  string bQt[2];
  logic [31:0] bLastR = '0;
  logic [2:0] bLastF = '0;

  task automatic stepBig(input logic v, input logic [31:0] a, input logic [31:0] b,
                         input logic s, input logic [31:0] er, input logic [2:0] ef,
                         input string tag);
    @(negedge clk);
    if (bQv[1]) begin
      report(bOutV && bRes == bQr[1] && {bOvf, bUdf, bInv} == bQf[1], bQt[1],
             {28'd0, bOutV, bOvf, bUdf, bInv, bRes}, {28'd0, 1'b1, bQf[1], bQr[1]});
      bLastR = bQr[1];
      bLastF = bQf[1];
    end else begin
      report(!bOutV && bRes == bLastR && {bOvf, bUdf, bInv} == bLastF, "R9 idle hold",
             {28'd0, bOutV, bOvf, bUdf, bInv, bRes}, {28'd0, 1'b0, bLastF, bLastR});
    end
    bQv[1] = bQv[0]; bQr[1] = bQr[0]; bQf[1] = bQf[0]; bQt[1] = bQt[0];
    bQv[0] = v; bQr[0] = er; bQf[0] = ef; bQt[0] = tag;
    bValid = v; bA = a; bB = b; bSub = s;
  endtask

  // ---- reduced-format pipeline bookkeeping ----
  logic mQv[2] = '{1'b0, 1'b0};
  logic [7:0] mQr[2];
  logic [2:0] mQf[2];
  string mQt[2];
  logic [7:0] mLastR = '0;
  logic [2:0] mLastF = '0;

  task automatic stepMini(input logic v, input logic [7:0] a, input logic [7:0] b,
                          input logic s);
    logic [66:0] r;
    string tag;
    r = refAdd(4, 3, {56'd0, a}, {56'd0, b}, s);
    if (r[64]) tag = "R7 sweep inv";
    else if (r[66]) tag = "R5 sweep ovf";
    else if (r[65]) tag = "R6 sweep udf";
    else if (r[6:3] == 4'hF && r[2:0] != 3'd0) tag = "R7 sweep nan";
    else if (r[6:3] == 4'hF) tag = "R8 sweep inf";
    else if (r[6:0] == 7'd0) tag = "R4 sweep zero";
    else tag = "R2 sweep";
    @(negedge clk);
    if (mQv[1]) begin
      report(mOutV && mRes == mQr[1] && {mOvf, mUdf, mInv} == mQf[1], mQt[1],
             {52'd0, mOutV, mOvf, mUdf, mInv, mRes}, {52'd0, 1'b1, mQf[1], mQr[1]});
      mLastR = mQr[1];
      mLastF = mQf[1];
    end else begin
      report(!mOutV && mRes == mLastR && {mOvf, mUdf, mInv} == mLastF, "R9 idle hold mini",
             {52'd0, mOutV, mOvf, mUdf, mInv, mRes}, {52'd0, 1'b0, mLastF, mLastR});
    end
    mQv[1] = mQv[0]; mQr[1] = mQr[0]; mQf[1] = mQf[0]; mQt[1] = mQt[0];
    mQv[0] = v; mQr[0] = r[7:0]; mQf[0] = r[66:64]; mQt[0] = {tag, " a=", $sformatf("%h b=%h s=%0d", a, b, s)};
    mValid = v; mA = a; mB = b; mSub = s;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    report(!bOutV && bRes == '0 && !bOvf && !bUdf && !bInv, "R10 reset",
           {28'd0, bOutV, bOvf, bUdf, bInv, bRes}, 64'd0);
    report(!mOutV && mRes == '0 && !mOvf && !mUdf && !mInv, "R10 reset mini",
           {52'd0, mOutV, mOvf, mUdf, mInv, mRes}, 64'd0);
    rstN = 1'b1;

    stepBig(1, 32'h43802000, 32'h43B2E000, 0, 32'h44198000, 3'b000, "R1 256.25+357.75");
    stepBig(1, 32'h47B30CB8, 32'h43B2E000, 0, 32'h47B3BF98, 3'b000, "R1 91673.4375+357.75");
    stepBig(1, 32'h47B3BF98, 32'h43B2E000, 1, 32'h47B30CB8, 3'b000, "R2 sub back");
    stepBig(1, 32'h3F800000, 32'h40400000, 1, 32'hC0000000, 3'b000, "R2 1-3");
    stepBig(0, '0, '0, 0, '0, '0, "");
    stepBig(0, '0, '0, 0, '0, '0, "");
    stepBig(1, 32'h3F800000, 32'h33800000, 0, 32'h3F800000, 3'b000, "R3 tie even down");
    stepBig(1, 32'h3F800001, 32'h33800000, 0, 32'h3F800002, 3'b000, "R3 tie odd up");
    stepBig(1, 32'h3F800000, 32'h33800001, 0, 32'h3F800001, 3'b000, "R3 above half");
    stepBig(1, 32'h3F7FFFFF, 32'h33800000, 0, 32'h3F800000, 3'b000, "R3 round carry");
    stepBig(1, 32'h3F800000, 32'h3F800000, 1, 32'h00000000, 3'b000, "R4 cancel");
    stepBig(1, 32'h80000000, 32'h80000000, 0, 32'h80000000, 3'b000, "R4 neg zeros");
    stepBig(1, 32'h7F7FFFFF, 32'h7F7FFFFF, 0, 32'h7F800000, 3'b100, "R5 ovf pos");
    stepBig(1, 32'hFF7FFFFF, 32'hFF7FFFFF, 0, 32'hFF800000, 3'b100, "R5 ovf neg");
    stepBig(1, 32'h00800001, 32'h00800000, 1, 32'h00000000, 3'b010, "R6 flush");
    stepBig(1, 32'h00400000, 32'h00400000, 0, 32'h00800000, 3'b000, "R6 denorm sum");
    stepBig(1, 32'h80000001, 32'h80000001, 0, 32'h80000000, 3'b010, "R6 flush neg");
    stepBig(1, 32'h7FC00001, 32'h3F800000, 0, 32'h7FC00000, 3'b000, "R7 nan in");
    stepBig(1, 32'h7F800000, 32'h7F800000, 1, 32'h7FC00000, 3'b001, "R7 inf-inf");
    stepBig(1, 32'h7F800000, 32'h3F800000, 0, 32'h7F800000, 3'b000, "R8 inf+1");
    stepBig(1, 32'h3F800000, 32'h7F800000, 1, 32'hFF800000, 3'b000, "R8 1-inf");
    stepBig(0, '0, '0, 0, '0, '0, "");
    stepBig(0, '0, '0, 0, '0, '0, "");
    stepBig(0, '0, '0, 0, '0, '0, "");

    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          stepMini(1, 8'(a), 8'(b), 1'(s));
        end
      end
    end
    stepMini(0, '0, '0, 0);
    stepMini(0, '0, '0, 0);
    stepMini(0, '0, '0, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule